// File: doc/BRIEF.md
# Byte Program Retry Sequencer

This block drives a device programmer that burns a complete image into an electrically programmable ROM. It walks the address space from zero to the last location. For each location it fetches the source byte over a request/response port, sets up address and data, and fires a chip-enable program pulse whose length in clock cycles is set by an input. It then reads the cell back with output enable asserted and compares the result with the source byte. A mismatch triggers another pulse at the same address. A match moves on to the next address. The number of pulses per address is bounded, and a location that will not take its value stops the run with a fail result.

Once the last address has been written, the sequencer drops the programming supply back to the normal level. It then reads every location again and compares each one with the image. Any difference gives fail. A clean pass gives pass. All setup, hold and supply settling delays are cycle counts derived from a clock-frequency parameter and a setup time in microseconds.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset, busy, pass, fail, mem_ce_pulse, mem_oe, mem_drive, img_req and vpp_prog are all 0.
- R2: A start pulse while idle gives busy=1, vpp_prog=1 (program level) and mem_addr=0 on the next cycle. A start pulse while busy has no effect on the pulse sequence.
- R3: The programming supply is at program level, and address and data are driven unchanged, for at least SETUP_CYC = CLK_MHZ*SETUP_US cycles before every program pulse. Address and data stay driven for at least one cycle after the pulse ends.
- R4: Each program pulse lasts exactly pulse_len cycles. A pulse_len of 0 gives a one-cycle pulse.
- R5: After every pulse, mem_oe is held high for exactly SETUP_CYC cycles with the data bus not driven, and the read value is compared with the source byte. On a mismatch, the next pulse goes to the same address.
- R6: No address receives more than MAX_TRIES (25) pulses. If the verify after pulse MAX_TRIES still mismatches, the run ends with fail=1 and no further pulses are issued.
- R7: On a verify match, the attempt count is cleared and the next address is processed. Addresses are programmed in ascending order from 0 to the last address.
- R8: After the last address passes verify, vpp_prog returns to 0 and every location is read again with no pulses. If all of them match the image, the run ends with pass=1, fail=0.
- R9: Any mismatch during the final read-back ends the run with fail=1, pass=0.
- R10: pass and fail are never both 1. Both are 0 while busy. One of them is set in the cycle in which busy falls and is held until the next start, which clears both.
- R11: Each byte is obtained by raising img_req with img_addr equal to the current address. The data on img_data in the cycle img_valid is high is the byte that gets programmed and compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (ignored while busy) |
| pulse_len | input | PULSE_W | Program pulse length in cycles |
| img_req | output | 1 | Image byte request |
| img_addr | output | ADDR_W | Image byte address |
| img_data | input | DATA_W | Image byte response data |
| img_valid | input | 1 | Image response valid |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data driven to memory |
| mem_drive | output | 1 | Data bus driven by the programmer |
| mem_ce_pulse | output | 1 | Chip-enable program pulse |
| mem_oe | output | 1 | Verify read strobe (output enable) |
| mem_rdata | input | DATA_W | Data read from memory |
| vpp_prog | output | 1 | 1 selects program-level supply, 0 normal supply |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Run finished successfully |
| fail | output | 1 | Run finished with an error |

## Verification
The tightest collision is the last address reaching its verify on its final permitted pulse. In that one decision cycle, the pulse limit and the move to the final read-back compete. The bench builds a memory model whose last cell needs exactly 25 pulses in one run and 30 in another. It judges the result by the exact pulse sequence the scoreboard expects, by whether a read-back phase follows, and by which of pass or fail appears when busy drops. A second collision is a start pulse landing in the middle of a run. It is judged by the pulse sequence staying exactly as queued.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_SUPPLY,
    S_FETCH,
    S_SETUP,
    S_PULSE,
    S_HOLD,
    S_OE,
    S_CHECK,
    S_FIN_SUPPLY
  } seq_state_t;
endpackage

// File: rtl/bps_cycle_timer.sv
module bps_cycle_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/bps_retry_tracker.sv
module bps_retry_tracker #(
  parameter int MAX_TRIES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] LIMIT_M1 = CW'(MAX_TRIES - 1);

  logic [CW-1:0] tries_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tries_q <= '0;
    end else if (inc && tries_q != LIMIT_M1) begin
      tries_q <= tries_q + 1'b1;
    end
  end

  assign at_limit = (tries_q == LIMIT_M1);
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
  import bps_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PULSE_W   = 16,
  parameter int CLK_MHZ   = 125,
  parameter int SETUP_US  = 2,
  parameter int MAX_TRIES = 25
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [PULSE_W-1:0] pulse_len,
  output logic               img_req,
  output logic [ADDR_W-1:0]  img_addr,
  input  logic [DATA_W-1:0]  img_data,
  input  logic               img_valid,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_drive,
  output logic               mem_ce_pulse,
  output logic               mem_oe,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               vpp_prog,
  output logic               busy,
  output logic               pass,
  output logic               fail
);
  localparam int SETUP_CYC = CLK_MHZ * SETUP_US;
  localparam int SW        = $clog2(SETUP_CYC + 1);
  localparam int TW        = (PULSE_W > SW) ? PULSE_W : SW;
  localparam logic [TW-1:0]     SETUP_LD  = TW'(SETUP_CYC - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_t        state_q, nxt;
  logic              fin_q, fin_n;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              match_q;
  logic              t_load, t_done;
  logic [TW-1:0]     t_val, pulse_ld;
  logic              r_clr, r_inc, r_limit;
  logic              req_q, drive_q, ce_q, oe_q, vpp_q, busy_q, pass_q, fail_q;

  assign pulse_ld = (pulse_len == '0) ? '0 : TW'(pulse_len - 1'b1);

  bps_cycle_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  bps_retry_tracker #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk      (clk),
    .rst      (rst),
    .clr      (r_clr),
    .inc      (r_inc),
    .at_limit (r_limit)
  );

  always_comb begin
    nxt    = state_q;
    fin_n  = fin_q;
    t_load = 1'b0;
    t_val  = SETUP_LD;
    r_clr  = 1'b0;
    r_inc  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          nxt    = S_SUPPLY;
          fin_n  = 1'b0;
          t_load = 1'b1;
          r_clr  = 1'b1;
        end
      end
      S_SUPPLY: begin
        if (t_done) nxt = S_FETCH;
      end
      S_FETCH: begin
        if (img_valid) begin
          t_load = 1'b1;
          nxt    = fin_q ? S_OE : S_SETUP;
        end
      end
      S_SETUP: begin
        if (t_done) begin
          nxt    = S_PULSE;
          t_load = 1'b1;
          t_val  = pulse_ld;
        end
      end
      S_PULSE: begin
        if (t_done) begin
          nxt    = S_HOLD;
          t_load = 1'b1;
        end
      end
      S_HOLD: begin
        if (t_done) begin
          nxt    = S_OE;
          t_load = 1'b1;
        end
      end
      S_OE: begin
        if (t_done) nxt = S_CHECK;
      end
      S_CHECK: begin
        if (fin_q) begin
          if (!match_q || addr_q == LAST_ADDR) nxt = S_IDLE;
          else                                 nxt = S_FETCH;
        end else if (match_q) begin
          r_clr = 1'b1;
          if (addr_q == LAST_ADDR) begin
            nxt    = S_FIN_SUPPLY;
            t_load = 1'b1;
          end else begin
            nxt = S_FETCH;
          end
        end else if (r_limit) begin
          nxt = S_IDLE;
        end else begin
          r_inc  = 1'b1;
          nxt    = S_SETUP;
          t_load = 1'b1;
        end
      end
      S_FIN_SUPPLY: begin
        if (t_done) begin
          nxt   = S_FETCH;
          fin_n = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      fin_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      match_q <= 1'b0;
      req_q   <= 1'b0;
      drive_q <= 1'b0;
      ce_q    <= 1'b0;
      oe_q    <= 1'b0;
      vpp_q   <= 1'b0;
      busy_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      fin_q   <= fin_n;
      if (state_q == S_IDLE && start) begin
        addr_q <= '0;
      end else if (state_q == S_CHECK && nxt == S_FETCH) begin
        addr_q <= addr_q + 1'b1;
      end else if (state_q == S_CHECK && nxt == S_FIN_SUPPLY) begin
        addr_q <= '0;
      end
      if (state_q == S_FETCH && img_valid) data_q <= img_data;
      if (state_q == S_OE && t_done) match_q <= (mem_rdata == data_q);
      req_q   <= (nxt == S_FETCH);
      drive_q <= (nxt == S_SETUP) || (nxt == S_PULSE) || (nxt == S_HOLD);
      ce_q    <= (nxt == S_PULSE);
      oe_q    <= (nxt == S_OE);
      vpp_q   <= !fin_n && (nxt != S_IDLE) && (nxt != S_FIN_SUPPLY);
      busy_q  <= (nxt != S_IDLE);
      if (state_q == S_IDLE && start) begin
        pass_q <= 1'b0;
        fail_q <= 1'b0;
      end else if (state_q == S_CHECK && nxt == S_IDLE) begin
        pass_q <= fin_q && match_q;
        fail_q <= !(fin_q && match_q);
      end
    end
  end

  assign img_req      = req_q;
  assign img_addr     = addr_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = data_q;
  assign mem_drive    = drive_q;
  assign mem_ce_pulse = ce_q;
  assign mem_oe       = oe_q;
  assign vpp_prog     = vpp_q;
  assign busy         = busy_q;
  assign pass         = pass_q;
  assign fail         = fail_q;
endmodule

// File: rtl/byte_prog_seq_chk.sv
module byte_prog_seq_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              pass,
  input logic              fail,
  input logic              mem_ce_pulse,
  input logic              mem_oe,
  input logic              mem_drive,
  input logic              vpp_prog,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);
  AST_PULSE_AT_PROG_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    mem_ce_pulse |-> (vpp_prog && mem_drive)); // R3
  AST_PULSE_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_ce_pulse && $past(mem_ce_pulse)) |-> ($stable(mem_addr) && $stable(mem_wdata))); // R3
  AST_HOLD_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_pulse) |-> mem_drive); // R3
  AST_READ_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    mem_oe |-> (!mem_ce_pulse && !mem_drive)); // R5
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && vpp_prog)); // R2
  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail)); // R10
  AST_BUSY_HIDES_RESULT: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(pass || fail)); // R10
  AST_RESULT_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (pass || fail)); // R10
endmodule

bind byte_prog_seq byte_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .busy         (busy),
  .pass         (pass),
  .fail         (fail),
  .mem_ce_pulse (mem_ce_pulse),
  .mem_oe       (mem_oe),
  .mem_drive    (mem_drive),
  .vpp_prog     (vpp_prog),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata)
);

// File: tb/test_byte_prog_seq.sv
module test_byte_prog_seq;
  localparam int AW = 4;
  localparam int NB = 16;
  localparam int SETUP_CYC = 4;
  localparam int LIMIT = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [15:0] pulse_len = 16'd3;
  logic       img_req, img_valid = 1'b0;
  logic [AW-1:0] img_addr, mem_addr;
  logic [7:0] img_data = 8'h00, mem_wdata, mem_rdata;
  logic       mem_drive, mem_ce_pulse, mem_oe, vpp_prog, busy, pass, fail;

  int checks = 0;
  int errors = 0;

  logic [7:0] cells [NB];
  logic [7:0] img   [NB];
  int         need  [NB];
  int         hits  [NB];
  int         exp_q [$];
  int         exp_w = 1;
  bit         corrupt_en = 1'b0;
  int         corrupt_a = 0;

  always #4 clk = ~clk;

  byte_prog_seq #(.ADDR_W(AW), .DATA_W(8), .PULSE_W(16), .CLK_MHZ(2),
                  .SETUP_US(2), .MAX_TRIES(LIMIT)) i_byte_prog_seq (
    .clk(clk), .rst(rst), .start(start), .pulse_len(pulse_len),
    .img_req(img_req), .img_addr(img_addr), .img_data(img_data), .img_valid(img_valid),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_drive(mem_drive),
    .mem_ce_pulse(mem_ce_pulse), .mem_oe(mem_oe), .mem_rdata(mem_rdata),
    .vpp_prog(vpp_prog), .busy(busy), .pass(pass), .fail(fail)
  );

  assign mem_rdata = mem_oe ? cells[mem_addr] : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // image responder
  always @(negedge clk) begin
    if (img_req && !img_valid) begin
      img_valid <= 1'b1;
      img_data  <= img[img_addr];
    end else begin
      img_valid <= 1'b0;
    end
  end

  // memory model and scoreboard monitor
  bit p_ce = 0, p_oe = 0, p_vpp = 0;
  int wcnt = 0, ocnt = 0, stab = 0, vcnt = 0;
  logic [AW-1:0] p_addr = '0;
  logic [7:0]    p_data = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_ce_pulse && !p_ce) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 R7 unexpected pulse", int'(mem_addr), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(mem_addr) == e, "R5 R7 pulse address", int'(mem_addr), e);
        end
        chk(stab >= SETUP_CYC, "R3 data setup", stab, SETUP_CYC);
        chk(vcnt >= SETUP_CYC, "R3 supply setup", vcnt, SETUP_CYC);
        if (vpp_prog && mem_drive) begin
          hits[mem_addr]++;
          if (hits[mem_addr] >= need[mem_addr]) cells[mem_addr] = cells[mem_addr] & mem_wdata;
        end
        wcnt = 1;
      end else if (mem_ce_pulse) begin
        wcnt++;
      end
      if (!mem_ce_pulse && p_ce) chk(wcnt == exp_w, "R4 pulse width", wcnt, exp_w);
      if (mem_oe && !p_oe) ocnt = 1;
      else if (mem_oe) ocnt++;
      if (!mem_oe && p_oe) chk(ocnt == SETUP_CYC, "R5 read strobe length", ocnt, SETUP_CYC);
      if (corrupt_en && p_vpp && !vpp_prog) cells[corrupt_a] = cells[corrupt_a] ^ 8'h01;
      if (mem_drive && mem_addr == p_addr && mem_wdata == p_data) stab++;
      else stab = mem_drive ? 1 : 0;
      vcnt = vpp_prog ? vcnt + 1 : 0;
    end
    p_ce = mem_ce_pulse; p_oe = mem_oe; p_vpp = vpp_prog;
    p_addr = mem_addr; p_data = mem_wdata;
  end

  // driver: push the pulse addresses the requirements predict
  task automatic plan_pulses();
    for (int a = 0; a < NB; a++) begin
      int n;
      n = (need[a] > LIMIT) ? LIMIT : need[a];
      for (int k = 0; k < n; k++) exp_q.push_back(a);
      if (need[a] > LIMIT) break;
    end
  endtask

  task automatic prep(input int seed);
    for (int a = 0; a < NB; a++) begin
      cells[a] = 8'hFF;
      hits[a]  = 0;
      need[a]  = 1;
      img[a]   = 8'((a * 37 + seed) & 8'h7F);
    end
  endtask

  task automatic run_case(input int len, input bit exp_pass, input bit mid_start, input string tag);
    int guard;
    pulse_len = 16'(len);
    exp_w = (len == 0) ? 1 : len;
    plan_pulses();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {"R2 busy ", tag}, busy, 1);
    chk(vpp_prog == 1'b1, {"R2 supply ", tag}, vpp_prog, 1);
    chk(mem_addr == '0, {"R2 first address ", tag}, int'(mem_addr), 0);
    chk(!pass && !fail, {"R10 cleared ", tag}, int'({pass, fail}), 0);
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {"R2 start ignored ", tag}, busy, 1);
    end
    guard = 0;
    while (busy && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    chk(!busy, {"R10 run ends ", tag}, busy, 0);
    chk(pass == exp_pass && fail == !exp_pass, {"R8 R9 result ", tag},
        int'({pass, fail}), int'({exp_pass, !exp_pass}));
    chk(vpp_prog == 1'b0, {"R8 supply normal ", tag}, vpp_prog, 0);
    chk(exp_q.size() == 0, {"R6 R7 pulses missing ", tag}, exp_q.size(), 0);
    exp_q.delete();
    repeat (10) @(negedge clk);
    chk(pass == exp_pass && fail == !exp_pass, {"R10 result held ", tag},
        int'({pass, fail}), int'({exp_pass, !exp_pass}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    prep(5);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !pass && !fail, "R1 status idle", int'({busy, pass, fail}), 0);
    chk(!mem_ce_pulse && !mem_oe && !mem_drive && !img_req && !vpp_prog, "R1 memory side idle",
        int'({mem_ce_pulse, mem_oe, mem_drive, img_req, vpp_prog}), 0);

    // A: varied retry counts, start pulse in mid-run
    prep(5);
    for (int a = 0; a < NB; a++) need[a] = (a % 3) + 1;
    run_case(3, 1'b1, 1'b1, "A");
    for (int a = 0; a < NB; a++) chk(cells[a] == img[a], "R8 R11 image written", cells[a], img[a]);

    // B: zero length pulse, last cell needs exactly the limit
    prep(11);
    need[NB-1] = LIMIT;
    run_case(0, 1'b1, 1'b0, "B");
    chk(cells[NB-1] == img[NB-1], "R6 last cell at limit", cells[NB-1], img[NB-1]);

    // C: last cell exceeds the limit
    prep(19);
    need[NB-1] = LIMIT + 5;
    run_case(5, 1'b0, 1'b0, "C");
    chk(cells[NB-1] == 8'hFF, "R6 stubborn cell untouched", cells[NB-1], 8'hFF);
    chk(hits[NB-1] == LIMIT, "R6 pulse count", hits[NB-1], LIMIT);

    // D: disturbance before final read-back
    prep(23);
    corrupt_en = 1'b1;
    corrupt_a  = 6;
    run_case(2, 1'b0, 1'b0, "D");
    corrupt_en = 1'b0;

    // E: failure in the middle of the array
    prep(41);
    need[4] = 40;
    run_case(1, 1'b0, 1'b0, "E");
    chk(hits[5] == 0, "R6 no pulses after fail", hits[5], 0);
    chk(cells[3] == img[3], "R7 earlier cells written", cells[3], img[3]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule